// File: doc/BRIEF.md
# Storage Channel Interrupt Cause Register

This block gathers the two interrupt causes of a storage channel: a device interrupt and a memory/bus error raised during a DMA transfer. Each cause is latched in a sticky bit. An enable mask selects which pending causes drive a level interrupt output toward the host. Software sees the causes, the enable mask and a captured error address through a small word-aligned register window on a simple 32-bit register bus.

Causes are cleared in two ways. Software can write ones to a clear register. Causes are also cleared as a side effect whenever the host reads the device status byte while that byte reports not busy. A read made while the device is busy leaves the causes pending. For the error cause, the block keeps the 64-bit bus address of the first failing access. It holds that address until the error cause has been cleared.

Top module: `stor_irq_cause`

## Requirements
- R1: After a synchronous reset, all causes, the enable mask and the captured error address are zero, and `irq_out` is low.
- R2: A one-cycle pulse on `dev_evt` sets cause bit 0, and a pulse on `err_evt` sets cause bit 1. A read of word 3 (byte offset 0x0C) returns the cause bits in bits [1:0] with zeros above.
- R3: A write to word 7 (byte offset 0x1C) clears each cause whose bit is 1 in the write data and leaves the causes whose bits are 0. Word 7 reads as zero.
- R4: A write to word 5 (byte offset 0x14) sets each enable bit whose write-data bit is 1. Zero bits leave the mask unchanged, so enables are never cleared by a write. Word 5 reads back the mask in bits [1:0].
- R5: `irq_out` goes high one clock after some cause is both pending and enabled. It is low one clock after no enabled cause is pending. A pending cause that is disabled does not raise it.
- R6: A pulse on `stat_rd` while `stat_byte` bit 7 (busy) is 0 clears every pending cause.
- R7: A pulse on `stat_rd` while `stat_byte` bit 7 is 1 leaves every cause unchanged.
- R8: A cause event arriving in the same cycle as a clear (register write or status read) leaves that cause set.
- R9: The error address is captured from `err_addr_in` only when `err_evt` arrives while cause bit 1 is clear. Later errors do not overwrite it. Word 0 returns the low 32 bits and word 1 the high 32 bits.
- R10: A read is returned on `bus_rdata` with `bus_rdata_vld` high in the cycle after `bus_rd`. Byte-address bits [1:0] are ignored. Unmapped words read zero, and writes to words other than 5 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rdata_vld | output | 1 | Read data valid, one cycle after `bus_rd` |
| dev_evt | input | 1 | Device interrupt event pulse |
| err_evt | input | 1 | Memory/bus error event pulse |
| err_addr_in | input | 64 | Bus address of the failing access, sampled with `err_evt` |
| stat_rd | input | 1 | Host read of the device status byte |
| stat_byte | input | 8 | Device status byte returned by that read; bit 7 is busy |
| irq_out | output | 1 | Registered level interrupt to the host |

## Verification
The hardest cases to reach are the collisions: a cause event in the same cycle as a write-one-to-clear or a not-busy status read, and a second error arriving while the first one is still pending. The stimulus uses one cycle-level driver that can assert any mix of events, a register write and a status read together. The collisions are therefore built by naming them in a single call. Each one is followed by register reads, so the cause bits and the captured address are observed at the bus after every collision.

// File: rtl/icr_pkg.sv
package icr_pkg;
  localparam int unsigned CAUSE_N   = 2;
  localparam int unsigned CAUSE_DEV = 0;
  localparam int unsigned CAUSE_ERR = 1;
  // word indices (byte offset / 4)
  localparam int unsigned W_ERR_LO  = 0;
  localparam int unsigned W_ERR_HI  = 1;
  localparam int unsigned W_STATUS  = 3;
  localparam int unsigned W_EN_SET  = 5;
  localparam int unsigned W_CLEAR   = 7;
endpackage

// File: rtl/icr_cause_bank.sv
module icr_cause_bank
  import icr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [CAUSE_N-1:0] evt,
  input  logic [CAUSE_N-1:0] clr_mask,
  input  logic               clr_all,
  output logic [CAUSE_N-1:0] cause_q
);
  genvar gi;
  generate
    for (gi = 0; gi < CAUSE_N; gi++) begin : g_bit
      logic keep;
      assign keep = cause_q[gi] & ~clr_mask[gi] & ~clr_all;
      always_ff @(posedge clk) begin
        if (rst) cause_q[gi] <= 1'b0;
        else     cause_q[gi] <= evt[gi] | keep;  // new event wins over clear
      end
    end
  endgenerate
endmodule

// File: rtl/icr_err_capture.sv
module icr_err_capture #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_evt,
  input  logic              armed,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)                   addr_q <= '0;
    else if (err_evt && armed) addr_q <= addr_in;
  end
endmodule

// File: rtl/icr_bus_regs.sv
module icr_bus_regs
  import icr_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned ERR_ADDR_W = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [CAUSE_N-1:0]    cause,
  input  logic [ERR_ADDR_W-1:0] err_addr,
  output logic [CAUSE_N-1:0]    en_q,
  output logic [CAUSE_N-1:0]    clr_mask,
  output logic [DATA_W-1:0]     rdata,
  output logic                  rdata_vld
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned PAD_W  = 2 * DATA_W;

  logic [WIDX_W-1:0] word;
  logic [PAD_W-1:0]  err_pad;
  logic [DATA_W-1:0] rmux;

  assign word    = bus_addr[ADDR_W-1:2];
  assign err_pad = PAD_W'(err_addr);

  assign clr_mask = (bus_wr && word == WIDX_W'(W_CLEAR)) ? bus_wdata[CAUSE_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (bus_wr && word == WIDX_W'(W_EN_SET)) en_q <= en_q | bus_wdata[CAUSE_N-1:0];
  end

  always_comb begin
    rmux = '0;
    if (word == WIDX_W'(W_ERR_LO))      rmux = err_pad[DATA_W-1:0];
    else if (word == WIDX_W'(W_ERR_HI)) rmux = err_pad[PAD_W-1:DATA_W];
    else if (word == WIDX_W'(W_STATUS)) rmux = DATA_W'(cause);
    else if (word == WIDX_W'(W_EN_SET)) rmux = DATA_W'(en_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      rdata_vld <= bus_rd;
      if (bus_rd) rdata <= rmux;
    end
  end
endmodule

// File: rtl/stor_irq_cause.sv
module stor_irq_cause
  import icr_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned ERR_ADDR_W = 64,
  parameter int unsigned STAT_W     = 8,
  parameter int unsigned BUSY_BIT   = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bus_rdata_vld,
  input  logic                  dev_evt,
  input  logic                  err_evt,
  input  logic [ERR_ADDR_W-1:0] err_addr_in,
  input  logic                  stat_rd,
  input  logic [STAT_W-1:0]     stat_byte,
  output logic                  irq_out
);
  logic [CAUSE_N-1:0]    evt;
  logic [CAUSE_N-1:0]    cause_q;
  logic [CAUSE_N-1:0]    en_q;
  logic [CAUSE_N-1:0]    clr_mask;
  logic                  stat_clr;
  logic [ERR_ADDR_W-1:0] err_addr_q;

  always_comb begin
    evt            = '0;
    evt[CAUSE_DEV] = dev_evt;
    evt[CAUSE_ERR] = err_evt;
  end

  assign stat_clr = stat_rd & ~stat_byte[BUSY_BIT];

  icr_cause_bank u_cause (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .clr_mask (clr_mask),
    .clr_all  (stat_clr),
    .cause_q  (cause_q)
  );

  icr_err_capture #(.ADDR_W(ERR_ADDR_W)) u_errcap (
    .clk     (clk),
    .rst     (rst),
    .err_evt (err_evt),
    .armed   (~cause_q[CAUSE_ERR]),
    .addr_in (err_addr_in),
    .addr_q  (err_addr_q)
  );

  icr_bus_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ERR_ADDR_W(ERR_ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cause     (cause_q),
    .err_addr  (err_addr_q),
    .en_q      (en_q),
    .clr_mask  (clr_mask),
    .rdata     (bus_rdata),
    .rdata_vld (bus_rdata_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(cause_q & en_q);
  end
endmodule

// File: rtl/icr_checker.sv
module icr_checker
  import icr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned ERR_ADDR_W = 64,
  parameter int unsigned STAT_W     = 8,
  parameter int unsigned BUSY_BIT   = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  wbit0,
  input logic                  bus_rdata_vld,
  input logic                  dev_evt,
  input logic                  err_evt,
  input logic                  stat_rd,
  input logic [STAT_W-1:0]     stat_byte,
  input logic                  irq_out,
  input logic [CAUSE_N-1:0]    cause,
  input logic [CAUSE_N-1:0]    en,
  input logic [ERR_ADDR_W-1:0] err_addr
);
  logic clr_wr;
  assign clr_wr = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(W_CLEAR));

  AST_DEV_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    dev_evt |=> cause[CAUSE_DEV]); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && wbit0 && !dev_evt) |=> !cause[CAUSE_DEV]); // R3
  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((en & $past(en)) == $past(en))); // R4
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((cause & en) == '0) |=> !irq_out); // R5
  AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !stat_byte[BUSY_BIT] && !dev_evt && !err_evt) |=> (cause == '0)); // R6
  AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && stat_byte[BUSY_BIT] && !clr_wr) |=> ((cause & $past(cause)) == $past(cause))); // R7
  AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (err_evt && (stat_rd || clr_wr)) |=> cause[CAUSE_ERR]); // R8
  AST_ERR_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    cause[CAUSE_ERR] |=> $stable(err_addr)); // R9
  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rdata_vld); // R10
endmodule

bind stor_irq_cause icr_checker #(
  .ADDR_W(ADDR_W), .ERR_ADDR_W(ERR_ADDR_W), .STAT_W(STAT_W), .BUSY_BIT(BUSY_BIT)
) u_icr_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_addr      (bus_addr),
  .wbit0         (bus_wdata[0]),
  .bus_rdata_vld (bus_rdata_vld),
  .dev_evt       (dev_evt),
  .err_evt       (err_evt),
  .stat_rd       (stat_rd),
  .stat_byte     (stat_byte),
  .irq_out       (irq_out),
  .cause         (cause_q),
  .en            (en_q),
  .err_addr      (err_addr_q)
);

// File: tb/stor_irq_cause_bench.sv
module stor_irq_cause_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rdata_vld;
  logic        dev_evt, err_evt;
  logic [63:0] err_addr_in;
  logic        stat_rd;
  logic [7:0]  stat_byte;
  logic        irq_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  stor_irq_cause u_stor_irq_cause (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdata_vld(bus_rdata_vld),
    .dev_evt(dev_evt), .err_evt(err_evt), .err_addr_in(err_addr_in),
    .stat_rd(stat_rd), .stat_byte(stat_byte), .irq_out(irq_out)
  );

  typedef struct { logic [31:0] data; string tag; } exp_t;
  exp_t exp_q[$];

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model
  logic [1:0]  m_cause = '0;
  logic [1:0]  m_en    = '0;
  logic [63:0] m_eaddr = '0;

  function automatic logic [31:0] model_read(input logic [4:0] a);
    case (a[4:2])
      3'd0: return m_eaddr[31:0];
      3'd1: return m_eaddr[63:32];
      3'd3: return {30'd0, m_cause};
      3'd5: return {30'd0, m_en};
      default: return 32'd0;
    endcase
  endfunction

  // one cycle with any mix of stimuli
  task automatic step(input bit dv, input bit er, input logic [63:0] ea,
                      input bit wr, input logic [4:0] a, input logic [31:0] wd,
                      input bit sr, input logic [7:0] sb);
    logic [1:0] clr;
    dev_evt = dv; err_evt = er; err_addr_in = ea;
    bus_wr = wr; bus_addr = a; bus_wdata = wd;
    stat_rd = sr; stat_byte = sb;
    clr = (wr && a[4:2] == 3'd7) ? wd[1:0] : 2'b00;
    if (sr && !sb[7]) clr = 2'b11;
    if (er && !m_cause[1]) m_eaddr = ea;
    m_cause = {er, dv} | (m_cause & ~clr);
    if (wr && a[4:2] == 3'd5) m_en = m_en | wd[1:0];
    @(negedge clk);
    dev_evt = 0; err_evt = 0; bus_wr = 0; stat_rd = 0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    exp_t e;
    e.data = model_read(a); e.tag = tag;
    exp_q.push_back(e);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    step(0, 0, '0, 1, a, d, 0, 8'h00);
  endtask

  task automatic check_irq(input string tag);
    @(negedge clk);
    n_tests++;
    if (irq_out !== |(m_cause & m_en)) begin
      n_fail++;
      $display("FAIL %s irq_out actual=%0b expected=%0b", tag, irq_out, |(m_cause & m_en));
    end
  endtask

  // monitor: compare read results in order
  always @(negedge clk) begin
    if (!rst && bus_rdata_vld) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (bus_rdata !== e.data) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", e.tag, bus_rdata, e.data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    dev_evt = 0; err_evt = 0; err_addr_in = '0; stat_rd = 0; stat_byte = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check_irq("R1");
    rd(5'h00, "R1 err lo"); rd(5'h04, "R1 err hi");
    rd(5'h0C, "R1 cause"); rd(5'h14, "R1 enable");
    // R2 device event, R5 disabled cause keeps irq low
    step(1, 0, '0, 0, 0, 0, 0, 0);
    rd(5'h0C, "R2 dev cause");
    check_irq("R5 disabled");
    // R4 enable set, R5 irq rises
    wr(5'h14, 32'h1);
    rd(5'h14, "R4 enable readback");
    check_irq("R5 enabled");
    wr(5'h14, 32'h0);
    rd(5'h14, "R4 zero write keeps");
    // R2/R9 first error captured
    step(0, 1, 64'hDEAD_BEEF_1234_5678, 0, 0, 0, 0, 0);
    rd(5'h0C, "R2 both causes");
    rd(5'h00, "R9 err lo"); rd(5'h04, "R9 err hi");
    wr(5'h14, 32'h3);
    // R9 second error does not overwrite
    step(0, 1, 64'h0BAD_F00D_0000_0001, 0, 0, 0, 0, 0);
    rd(5'h00, "R9 held lo"); rd(5'h04, "R9 held hi");
    // R3 w1c clears only bit 1
    wr(5'h1C, 32'h2);
    rd(5'h0C, "R3 partial clear");
    rd(5'h1C, "R3 clear reads zero");
    // R7 busy status read keeps
    step(0, 0, '0, 0, 0, 0, 1, 8'h80);
    rd(5'h0C, "R7 busy keeps");
    check_irq("R7 irq still high");
    // R6 not-busy status read clears
    step(0, 0, '0, 0, 0, 0, 1, 8'h50);
    rd(5'h0C, "R6 stat clears");
    check_irq("R5 irq falls");
    // R8 event with w1c
    step(1, 0, '0, 1, 5'h1C, 32'h3, 0, 0);
    rd(5'h0C, "R8 evt vs w1c");
    // R8 event with status clear
    step(0, 1, 64'h1111_2222_3333_4444, 0, 0, 0, 1, 8'h00);
    rd(5'h0C, "R8 evt vs stat read");
    rd(5'h00, "R9 recapture after clear");
    // R3 full clear then new error recaptured
    wr(5'h1C, 32'h3);
    rd(5'h0C, "R3 full clear");
    step(0, 1, 64'hCAFE_0000_0000_00AA, 0, 0, 0, 0, 0);
    rd(5'h04, "R9 new capture hi");
    // R10 read-only words and unaligned low bits
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h0F, "R10 low addr bits ignored");
    rd(5'h01, "R10 err lo not writable");
    rd(5'h08, "R10 unmapped reads zero");
    repeat (3) @(negedge clk);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10 reads outstanding actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule